// File: doc/BRIEF.md
# Tributary Transmit Elastic Store with Bit Justification

This block takes a gapped DS1 or E1 tributary (clock enable, serial data and a frame sync, all in the tributary clock domain) and holds it until a local clock domain consumes it one payload slot at a time. The two domains are decoupled through a dual-clock store whose write and read pointers cross as Gray codes through two-stage synchronisers. Once per tributary superframe the local side strobes the block. It then compares the store's fill against a centre level and picks positive, null or negative justification, which it presents as two triple-repeated C-bit groups. The S-bit payload that a decision turns into data is fetched through the ordinary read port.

The storage changes with the mapping mode. In asynchronous and bit-synchronous modes it is a serial FIFO of 64 one-bit entries. In byte-synchronous mode it is 8 words of 9 bits: an assembled byte, most significant bit first, plus a marker bit. The marker bit flags the byte that began with a frame sync, and reading that byte raises a marker output for a downstream pointer generator. A write into a full store and a read from an empty store each slip the store back to half depth and set a sticky flag, which stays set until its clear input is pulsed. The block also outputs the fixed tributary pointer for the selected tributary width. The mode and tributary-width inputs are static while the block runs and are changed only under reset.

Top module: `tes_elastic_store`

## Requirements
- R1: In asynchronous and bit-synchronous modes (`mode` 0 and 1), bits come out on `rd_data[0]` in the order they were written, with `rd_data[7:1]` zero. The store holds 64 bits.
- R2: In byte-synchronous mode (`mode` 2), each group of 8 enabled input bits forms one byte, and the first bit received becomes bit 7. Bytes are read out in order on `rd_data`, and the store holds 8 bytes.
- R3: `rd_v5` is high with a read byte exactly when `trib_fsync` was high on that byte's first bit. A bit that arrives with `trib_fsync` high always starts a new byte. `rd_v5` is never high outside byte-synchronous mode.
- R4: An enabled write into a full store is dropped, sets `ovf_flag`, and moves the write pointer so that the fill becomes half the current depth. The oldest half of the data is kept.
- R5: `rd_en` on an empty store produces no `rd_valid`, sets `unf_flag`, and moves the read pointer so that the fill becomes half the current depth.
- R6: `ovf_flag` and `unf_flag` stay set until `ovf_clr` or `unf_clr` respectively is pulsed. A new event in the same cycle as the clear keeps the flag set.
- R7: `vt_pointer` is 78 when `trib_e1` is 0 and 105 when `trib_e1` is 1.
- R8: In asynchronous mode, `sf_strobe` latches `just_code`: 1 (positive) if fill < 28, 2 (negative) if fill > 36, otherwise 0 (null). The fill used is the one before any read made in the same cycle.
- R9: `c1_bits` is 3'b111 when `just_code` is 2 and 3'b000 otherwise. `c2_bits` is 3'b111 when `just_code` is 1 and 3'b000 otherwise.
- R10: In bit-synchronous and byte-synchronous modes, `sf_strobe` always latches `just_code` 0.
- R11: A `rd_en` on a non-empty store gives `rd_valid` high with the data on the next local clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| trib_clk | input | 1 | Tributary-side clock |
| trib_rst | input | 1 | Synchronous active-high reset, tributary side |
| trib_en | input | 1 | Tributary bit enable (gapped clock) |
| trib_data | input | 1 | Tributary serial data |
| trib_fsync | input | 1 | Frame sync, marks the first bit of a marked byte |
| ovf_clr | input | 1 | Clears the overflow flag (tributary side) |
| ovf_flag | output | 1 | Sticky overflow flag |
| loc_clk | input | 1 | Local mapping clock |
| loc_rst | input | 1 | Synchronous active-high reset, local side |
| mode | input | 2 | 0 asynchronous, 1 bit-synchronous, 2 byte-synchronous |
| trib_e1 | input | 1 | 0 narrow (1.5 Mbit/s) tributary, 1 wide (2 Mbit/s) tributary |
| rd_en | input | 1 | Payload slot request, one bit or one byte |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read bit (bit 0) or read byte |
| rd_v5 | output | 1 | Read byte carries the marker |
| sf_strobe | input | 1 | Superframe boundary, latches a justification decision |
| just_code | output | 2 | 0 null, 1 positive, 2 negative |
| c1_bits | output | 3 | First C-bit group |
| c2_bits | output | 3 | Second C-bit group |
| unf_clr | input | 1 | Clears the underflow flag (local side) |
| unf_flag | output | 1 | Sticky underflow flag |
| vt_pointer | output | 10 | Fixed tributary pointer value |

## Verification
The justification decision and a payload read can happen in the same local cycle, and the decision must use the fill from before that read. The bench fills the store to exactly the lower threshold. It then raises `sf_strobe` and `rd_en` together and expects a null decision together with the correct popped bit. A second strobe one bit lower must then give positive justification. A slip and a flag clear can also coincide: overflow and underflow are provoked on a store that is full and on one that is empty, and the bench checks that the decision made afterwards reflects the re-centred fill.

// File: rtl/tes_pkg.sv
`timescale 1ns/1ps
package tes_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC    = 2'd0,
        MODE_BITSYNC  = 2'd1,
        MODE_BYTESYNC = 2'd2,
        MODE_RSVD     = 2'd3
    } map_mode_e;

    typedef enum logic [1:0] {
        JUST_NULL = 2'd0,
        JUST_POS  = 2'd1,
        JUST_NEG  = 2'd2
    } just_e;

    typedef struct packed {
        logic       marker;
        logic [7:0] data;
    } tword_t;

    typedef struct packed {
        logic [2:0] c1;
        logic [2:0] c2;
    } cgroup_t;

    localparam int PTR_W      = 10;
    localparam int PTR_NARROW = 78;
    localparam int PTR_WIDE   = 105;

    // each group repeats its flag three times for a majority vote downstream
    function automatic cgroup_t code_cbits(input just_e j);
        cgroup_t g;
        g.c1 = {3{j == JUST_NEG}};
        g.c2 = {3{j == JUST_POS}};
        return g;
    endfunction

    function automatic logic [PTR_W-1:0] fixed_pointer(input logic wide);
        return wide ? PTR_W'(PTR_WIDE) : PTR_W'(PTR_NARROW);
    endfunction

endpackage

// File: rtl/tes_gray_sync.sv
`timescale 1ns/1ps
module tes_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // binary bit i is the parity of all Gray bits at or above i
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(sync_q >> i);
        end
    end
endmodule

// File: rtl/tes_store.sv
`timescale 1ns/1ps
module tes_store
    import tes_pkg::*;
#(
    parameter int BIT_AW  = 6,
    parameter int BYTE_AW = 3
) (
    input  logic               wclk,
    input  logic               bit_we,
    input  logic [BIT_AW-1:0]  bit_waddr,
    input  logic               bit_wdata,
    input  logic               byte_we,
    input  logic [BYTE_AW-1:0] byte_waddr,
    input  tword_t             byte_wdata,
    input  logic [BIT_AW-1:0]  bit_raddr,
    input  logic [BYTE_AW-1:0] byte_raddr,
    output logic               bit_rdata,
    output tword_t             byte_rdata
);
    localparam int BIT_N  = 1 << BIT_AW;
    localparam int BYTE_N = 1 << BYTE_AW;

    logic [BIT_N-1:0] bit_mem;
    tword_t           byte_mem [BYTE_N];

    always_ff @(posedge wclk) begin
        if (bit_we) bit_mem[bit_waddr] <= bit_wdata;
    end

    for (genvar k = 0; k < BYTE_N; k++) begin : g_word
        always_ff @(posedge wclk) begin
            if (byte_we && byte_waddr == BYTE_AW'(k)) byte_mem[k] <= byte_wdata;
        end
    end

    assign bit_rdata  = bit_mem[bit_raddr];
    assign byte_rdata = byte_mem[byte_raddr];
endmodule

// File: rtl/tes_wr_side.sv
`timescale 1ns/1ps
module tes_wr_side
    import tes_pkg::*;
#(
    parameter int BIT_AW  = 6,
    parameter int BYTE_AW = 3,
    localparam int PW     = BIT_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  map_mode_e          mode,
    input  logic               en,
    input  logic               din,
    input  logic               fsync,
    input  logic               clr,
    input  logic [PW-1:0]      rd_bin,
    output logic               bit_we,
    output logic [BIT_AW-1:0]  bit_waddr,
    output logic               bit_wdata,
    output logic               byte_we,
    output logic [BYTE_AW-1:0] byte_waddr,
    output tword_t             byte_wdata,
    output logic [PW-1:0]      wr_gray,
    output logic               ovf_flag
);
    localparam logic [PW-1:0] BIT_DEPTH  = PW'(1 << BIT_AW);
    localparam logic [PW-1:0] BYTE_DEPTH = PW'(1 << BYTE_AW);

    logic [PW-1:0] wr_bin, wr_next, depth, fill;
    logic          byte_mode, push, full, overflow;
    logic [6:0]    shreg;
    logic [2:0]    bcnt, bit_idx;
    logic          mark_q;

    assign byte_mode = (mode == MODE_BYTESYNC);
    assign depth     = byte_mode ? BYTE_DEPTH : BIT_DEPTH;
    assign fill      = wr_bin - rd_bin;
    assign full      = fill >= depth;
    assign bit_idx   = fsync ? 3'd0 : bcnt;
    assign push      = byte_mode ? (en && bit_idx == 3'd7) : en;
    assign overflow  = push && full;

    assign bit_we            = push && !full && !byte_mode;
    assign bit_waddr         = wr_bin[BIT_AW-1:0];
    assign bit_wdata         = din;
    assign byte_we           = push && !full && byte_mode;
    assign byte_waddr        = wr_bin[BYTE_AW-1:0];
    assign byte_wdata.marker = mark_q;
    assign byte_wdata.data   = {shreg, din};

    always_comb begin
        if (overflow)  wr_next = rd_bin + (depth >> 1);
        else if (push) wr_next = wr_bin + 1'b1;
        else           wr_next = wr_bin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin   <= '0;
            wr_gray  <= '0;
            shreg    <= '0;
            bcnt     <= '0;
            mark_q   <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            wr_bin  <= wr_next;
            wr_gray <= wr_next ^ (wr_next >> 1);
            if (en && byte_mode) begin
                shreg <= {shreg[5:0], din};
                bcnt  <= bit_idx + 3'd1;
                if (bit_idx == 3'd0) mark_q <= fsync;
            end
            if (overflow) ovf_flag <= 1'b1;
            else if (clr) ovf_flag <= 1'b0;
        end
    end

    a_r4_overflow_flags: assert property (@(posedge clk) disable iff (rst)
        overflow |=> ovf_flag);
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !clr |=> ovf_flag);
    a_r4_no_store_when_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !(bit_we || byte_we));
endmodule

// File: rtl/tes_rd_side.sv
`timescale 1ns/1ps
module tes_rd_side
    import tes_pkg::*;
#(
    parameter int BIT_AW  = 6,
    parameter int BYTE_AW = 3,
    parameter int HYST    = 4,
    localparam int PW     = BIT_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  map_mode_e          mode,
    input  logic               rd_en,
    input  logic               sf_strobe,
    input  logic               clr,
    input  logic [PW-1:0]      wr_bin,
    input  logic               bit_rdata,
    input  tword_t             byte_rdata,
    output logic [BIT_AW-1:0]  bit_raddr,
    output logic [BYTE_AW-1:0] byte_raddr,
    output logic [PW-1:0]      rd_gray,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic               rd_v5,
    output logic               unf_flag,
    output just_e              just_q,
    output cgroup_t            cbits
);
    localparam logic [PW-1:0] BIT_DEPTH  = PW'(1 << BIT_AW);
    localparam logic [PW-1:0] BYTE_DEPTH = PW'(1 << BYTE_AW);
    localparam logic [PW-1:0] LO_LEVEL   = PW'((1 << (BIT_AW - 1)) - HYST);
    localparam logic [PW-1:0] HI_LEVEL   = PW'((1 << (BIT_AW - 1)) + HYST);

    logic [PW-1:0] rd_bin, rd_next, depth, fill;
    logic          byte_mode, empty, pop, underflow;
    just_e         just_d;

    assign byte_mode  = (mode == MODE_BYTESYNC);
    assign depth      = byte_mode ? BYTE_DEPTH : BIT_DEPTH;
    assign fill       = wr_bin - rd_bin;
    assign empty      = (fill == '0);
    assign pop        = rd_en && !empty;
    assign underflow  = rd_en && empty;
    assign bit_raddr  = rd_bin[BIT_AW-1:0];
    assign byte_raddr = rd_bin[BYTE_AW-1:0];
    assign cbits      = code_cbits(just_q);

    always_comb begin
        if (underflow) rd_next = wr_bin - (depth >> 1);
        else if (pop)  rd_next = rd_bin + 1'b1;
        else           rd_next = rd_bin;
    end

    always_comb begin
        if (mode != MODE_ASYNC)  just_d = JUST_NULL;
        else if (fill < LO_LEVEL) just_d = JUST_POS;
        else if (fill > HI_LEVEL) just_d = JUST_NEG;
        else                      just_d = JUST_NULL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin   <= '0;
            rd_gray  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_v5    <= 1'b0;
            unf_flag <= 1'b0;
            just_q   <= JUST_NULL;
        end else begin
            rd_bin   <= rd_next;
            rd_gray  <= rd_next ^ (rd_next >> 1);
            rd_valid <= pop;
            rd_v5    <= pop && byte_mode && byte_rdata.marker;
            if (pop) rd_data <= byte_mode ? byte_rdata.data : {7'd0, bit_rdata};
            if (sf_strobe) just_q <= just_d;
            if (underflow) unf_flag <= 1'b1;
            else if (clr)  unf_flag <= 1'b0;
        end
    end

    a_r5_underflow_flags: assert property (@(posedge clk) disable iff (rst)
        underflow |=> unf_flag);
    a_r5_no_data_on_empty: assert property (@(posedge clk) disable iff (rst)
        underflow |=> !rd_valid);
    a_r6_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        unf_flag && !clr |=> unf_flag);
    a_r11_valid_needs_request: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));
    a_r10_null_outside_async: assert property (@(posedge clk) disable iff (rst)
        sf_strobe && mode != MODE_ASYNC |=> just_q == JUST_NULL);
    a_r3_marker_byte_only: assert property (@(posedge clk) disable iff (rst)
        rd_v5 |-> rd_valid && mode == MODE_BYTESYNC);
endmodule

// File: rtl/tes_elastic_store.sv
`timescale 1ns/1ps
module tes_elastic_store
    import tes_pkg::*;
#(
    parameter int BIT_AW  = 6,
    parameter int BYTE_AW = 3,
    parameter int HYST    = 4
) (
    input  logic             trib_clk,
    input  logic             trib_rst,
    input  logic             trib_en,
    input  logic             trib_data,
    input  logic             trib_fsync,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    input  logic             loc_clk,
    input  logic             loc_rst,
    input  logic [1:0]       mode,
    input  logic             trib_e1,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rd_v5,
    input  logic             sf_strobe,
    output logic [1:0]       just_code,
    output logic [2:0]       c1_bits,
    output logic [2:0]       c2_bits,
    input  logic             unf_clr,
    output logic             unf_flag,
    output logic [PTR_W-1:0] vt_pointer
);
    localparam int PW = BIT_AW + 1;

    map_mode_e          mode_e;
    logic [PW-1:0]      wr_gray, rd_gray, wr_bin_l, rd_bin_t;
    logic               bit_we, bit_wdata, bit_rdata, byte_we;
    logic [BIT_AW-1:0]  bit_waddr, bit_raddr;
    logic [BYTE_AW-1:0] byte_waddr, byte_raddr;
    tword_t             byte_wdata, byte_rdata;
    just_e              just_q;
    cgroup_t            cbits;

    assign mode_e     = map_mode_e'(mode);
    assign just_code  = just_q;
    assign c1_bits    = cbits.c1;
    assign c2_bits    = cbits.c2;
    assign vt_pointer = fixed_pointer(trib_e1);

    tes_wr_side #(.BIT_AW(BIT_AW), .BYTE_AW(BYTE_AW)) u_wr (
        .clk(trib_clk), .rst(trib_rst), .mode(mode_e), .en(trib_en),
        .din(trib_data), .fsync(trib_fsync), .clr(ovf_clr), .rd_bin(rd_bin_t),
        .bit_we(bit_we), .bit_waddr(bit_waddr), .bit_wdata(bit_wdata),
        .byte_we(byte_we), .byte_waddr(byte_waddr), .byte_wdata(byte_wdata),
        .wr_gray(wr_gray), .ovf_flag(ovf_flag)
    );

    tes_gray_sync #(.W(PW)) u_sync_rd2wr (
        .clk(trib_clk), .rst(trib_rst), .gray_in(rd_gray), .bin_out(rd_bin_t)
    );

    tes_gray_sync #(.W(PW)) u_sync_wr2rd (
        .clk(loc_clk), .rst(loc_rst), .gray_in(wr_gray), .bin_out(wr_bin_l)
    );

    tes_store #(.BIT_AW(BIT_AW), .BYTE_AW(BYTE_AW)) u_store (
        .wclk(trib_clk), .bit_we(bit_we), .bit_waddr(bit_waddr),
        .bit_wdata(bit_wdata), .byte_we(byte_we), .byte_waddr(byte_waddr),
        .byte_wdata(byte_wdata), .bit_raddr(bit_raddr), .byte_raddr(byte_raddr),
        .bit_rdata(bit_rdata), .byte_rdata(byte_rdata)
    );

    tes_rd_side #(.BIT_AW(BIT_AW), .BYTE_AW(BYTE_AW), .HYST(HYST)) u_rd (
        .clk(loc_clk), .rst(loc_rst), .mode(mode_e), .rd_en(rd_en),
        .sf_strobe(sf_strobe), .clr(unf_clr), .wr_bin(wr_bin_l),
        .bit_rdata(bit_rdata), .byte_rdata(byte_rdata),
        .bit_raddr(bit_raddr), .byte_raddr(byte_raddr), .rd_gray(rd_gray),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_v5(rd_v5),
        .unf_flag(unf_flag), .just_q(just_q), .cbits(cbits)
    );

    always_comb begin
        a_r7_pointer_value: assert (vt_pointer == (trib_e1 ? PTR_W'(105) : PTR_W'(78)));
    end
endmodule

// File: tb/tes_elastic_store_bench.sv
`timescale 1ns/1ps
module tes_elastic_store_bench;
    import tes_pkg::*;

    logic       trib_clk = 0, trib_rst = 1, trib_en = 0, trib_data = 0, trib_fsync = 0;
    logic       ovf_clr = 0, ovf_flag;
    logic       loc_clk = 0, loc_rst = 1;
    logic [1:0] mode = 2'd0;
    logic       trib_e1 = 0, rd_en = 0, rd_valid, rd_v5, sf_strobe = 0, unf_clr = 0, unf_flag;
    logic [7:0] rd_data;
    logic [1:0] just_code;
    logic [2:0] c1_bits, c2_bits;
    logic [9:0] vt_pointer;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    logic [7:0] lfsr = 8'h5b;
    string data_tag = "R1";

    always #2 loc_clk = ~loc_clk;
    always #3 trib_clk = ~trib_clk;

    tes_elastic_store u_tes_elastic_store (
        .trib_clk(trib_clk), .trib_rst(trib_rst), .trib_en(trib_en),
        .trib_data(trib_data), .trib_fsync(trib_fsync), .ovf_clr(ovf_clr),
        .ovf_flag(ovf_flag), .loc_clk(loc_clk), .loc_rst(loc_rst), .mode(mode),
        .trib_e1(trib_e1), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_v5(rd_v5), .sf_strobe(sf_strobe), .just_code(just_code),
        .c1_bits(c1_bits), .c2_bits(c2_bits), .unf_clr(unf_clr),
        .unf_flag(unf_flag), .vt_pointer(vt_pointer)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever the design presents read data
    always @(posedge loc_clk) begin
        #1;
        if (!loc_rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk({data_tag, " unexpected read"}, 1, 0);
            end else begin
                logic [8:0] item;
                item = exp_q.pop_front();
                chk({data_tag, " read data"}, int'(rd_data), int'(item[7:0]));
                chk("R3 marker on read", int'(rd_v5), int'(item[8]));
            end
        end
    end

    task automatic do_reset(input logic [1:0] m, input logic e1);
        trib_rst = 1; loc_rst = 1; mode = m; trib_e1 = e1;
        repeat (4) @(negedge trib_clk);
        @(negedge loc_clk) loc_rst = 0;
        @(negedge trib_clk) trib_rst = 0;
        exp_q.delete();
        data_tag = (m == 2'd2) ? "R2" : "R1";
    endtask

    task automatic put_bit(input logic b, input logic fs);
        @(negedge trib_clk) begin trib_en = 1; trib_data = b; trib_fsync = fs; end
        @(negedge trib_clk) begin trib_en = 0; trib_fsync = 0; end
    endtask

    task automatic push_bits(input int n);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = lfsr[0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            put_bit(b, 1'b0);
            exp_q.push_back({8'd0, b});
        end
    endtask

    task automatic put_byte(input logic [7:0] v, input logic fs, input logic track);
        for (int i = 7; i >= 0; i--) put_bit(v[i], fs && i == 7);
        if (track) exp_q.push_back({fs, v});
    endtask

    task automatic settle();
        repeat (12) @(negedge loc_clk);
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge loc_clk) rd_en = 1;
            @(negedge loc_clk) rd_en = 0;
        end
    endtask

    task automatic strobe_chk(input string tag, input int exp_j);
        @(negedge loc_clk) sf_strobe = 1;
        @(negedge loc_clk) sf_strobe = 0;
        chk({tag, " decision"}, int'(just_code), exp_j);
        chk("R9 c1 group", int'(c1_bits), exp_j == 2 ? 7 : 0);
        chk("R9 c2 group", int'(c2_bits), exp_j == 1 ? 7 : 0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // reset state, narrow tributary pointer
        do_reset(2'd0, 1'b0);
        @(negedge loc_clk);
        chk("R11 reset valid", int'(rd_valid), 0);
        chk("R6 reset ovf", int'(ovf_flag), 0);
        chk("R6 reset unf", int'(unf_flag), 0);
        chk("R8 reset decision", int'(just_code), 0);
        chk("R7 narrow pointer", int'(vt_pointer), 78);

        // R8 thresholds and order of bits (R1)
        push_bits(27); settle();
        strobe_chk("R8 fill 27", 1);
        push_bits(1); settle();
        strobe_chk("R8 fill 28", 0);
        // read and decision in the same cycle: decision sees fill 28
        @(negedge loc_clk) begin rd_en = 1; sf_strobe = 1; end
        @(negedge loc_clk) begin rd_en = 0; sf_strobe = 0; end
        chk("R8 same-cycle read", int'(just_code), 0);
        chk("R11 valid after read", int'(exp_q.size()), 27);
        strobe_chk("R8 fill 27 after read", 1);
        push_bits(10); settle();
        strobe_chk("R8 fill 37", 2);
        read_n(1);
        strobe_chk("R8 fill 36", 0);
        read_n(36);
        @(negedge loc_clk);
        chk("R1 all bits drained", int'(exp_q.size()), 0);

        // R4 overflow in serial mode, R6 sticky
        do_reset(2'd0, 1'b0);
        push_bits(64);
        chk("R4 no overflow at 64", int'(ovf_flag), 0);
        put_bit(1'b1, 1'b0);
        chk("R4 overflow flag", int'(ovf_flag), 1);
        while (exp_q.size() > 32) void'(exp_q.pop_back());
        settle();
        strobe_chk("R4 recentred fill", 0);
        read_n(32);
        @(negedge loc_clk);
        chk("R4 kept oldest half", int'(exp_q.size()), 0);
        chk("R6 ovf held", int'(ovf_flag), 1);
        @(negedge trib_clk) ovf_clr = 1;
        @(negedge trib_clk) ovf_clr = 0;
        chk("R6 ovf cleared", int'(ovf_flag), 0);

        // R5 underflow
        do_reset(2'd0, 1'b0);
        settle();
        read_n(1);
        chk("R5 no valid on empty", int'(rd_valid), 0);
        chk("R5 underflow flag", int'(unf_flag), 1);
        settle();
        strobe_chk("R5 recentred fill", 0);
        chk("R6 unf held", int'(unf_flag), 1);
        @(negedge loc_clk) unf_clr = 1;
        @(negedge loc_clk) unf_clr = 0;
        chk("R6 unf cleared", int'(unf_flag), 0);

        // R10 bit-synchronous: no justification even when far from centre
        do_reset(2'd1, 1'b0);
        push_bits(50); settle();
        strobe_chk("R10 bitsync", 0);
        read_n(50);
        @(negedge loc_clk);
        chk("R1 bitsync drained", int'(exp_q.size()), 0);

        // R2/R3 byte-synchronous, wide tributary pointer
        do_reset(2'd2, 1'b1);
        @(negedge loc_clk);
        chk("R7 wide pointer", int'(vt_pointer), 105);
        put_byte(8'hA5, 1'b1, 1'b1);
        put_byte(8'h3C, 1'b0, 1'b1);
        put_byte(8'hF0, 1'b0, 1'b1);
        put_byte(8'h81, 1'b1, 1'b1);
        settle();
        strobe_chk("R10 bytesync", 0);
        read_n(4);
        @(negedge loc_clk);
        chk("R2 bytes drained", int'(exp_q.size()), 0);

        // R4 overflow in byte mode: depth 8, re-centre to 4
        do_reset(2'd2, 1'b1);
        for (int i = 0; i < 8; i++) put_byte(8'(8'h11 * (i + 1)), i == 2, 1'b1);
        chk("R4 byte no overflow at 8", int'(ovf_flag), 0);
        put_byte(8'hEE, 1'b0, 1'b0);
        chk("R4 byte overflow flag", int'(ovf_flag), 1);
        while (exp_q.size() > 4) void'(exp_q.pop_back());
        settle();
        read_n(4);
        @(negedge loc_clk);
        chk("R4 byte kept oldest half", int'(exp_q.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule